// File: doc/BRIEF.md
# Hypervisor Debug Trap Decision Unit

This block holds the hypervisor-level debug configuration register and judges each system-register access that the pipeline presents to it. Each access is judged as allowed, undefined or trapped. A trapped access also gets the privilege level that takes it and a six-bit syndrome code. The block also drives the effective values of the register's trap bits. Other controls can force these values, but the stored bits never change because of that.

A request gives the access encoding, a write flag with its data, an access class and the current privilege level (0 to 3). Four side inputs shape the result:
- a hypervisor-enabled flag;
- a general-trap flag;
- a nested-virtualisation flag;
- a trap bit owned by the highest privilege level.

The response appears one cycle after the request strobe. It carries the read data of a direct register read. The block does not take the exception. It does not hold the debug or counter registers it protects.

Top module: `hdbg_trap_unit`

## Requirements
- R1: After reset the stored register is all zeros, rsp_valid is 0, and all five effective trap outputs are 0 while gen_trap is 0.
- R2: An access to the configuration register is undefined (rsp_kind 1) at level 0, whatever the access class. The register is selected by the encoding 16'hE089, packed as {op0[1:0], op1[2:0], CRn[3:0], CRm[3:0], op2[2:0]}.
- R3: A configuration-register access at level 1 traps (rsp_kind 2) to level 2 with syndrome 0x18 when nest_virt is 1, and is undefined otherwise. Neither outcome changes the register.
- R4: At level 2 a configuration-register access traps to level 3 with syndrome 0x18 when upper_trap is 1, without changing the register. Otherwise it is allowed (rsp_kind 0) and reads or writes the register. At level 3 such an access is always allowed.
- R5: rsp_valid is 1 exactly in the cycle after a cycle with req_valid 1. The response fields in that cycle belong to that request. A write is visible on the effective outputs and on a later read from the next cycle on.
- R6: When gen_trap is 1, the effective routing bit eff_tde is 1. The routing bit is stored at bit 8.
- R7: When the routing bit is effectively 1, eff_tdra, eff_tdosa and eff_tda are 1. A direct read still returns the stored bits. The stored positions are bit 11 for the ROM-access trap, bit 10 for the OS-register trap and bit 9 for the debug-register trap.
- R8: At levels 0 and 1, with hyp_en 1 and eff_tda 1, debug accesses trap to level 2. Class 1 (64-bit) reports syndrome 0x18, class 2 (32-bit register move) reports 0x05, and class 3 (32-bit load/store) reports 0x06.
- R9: At levels 0 and 1, with hyp_en 1 and stored bit 6 set, counter accesses trap to level 2. Class 4 (64-bit) reports 0x18, class 5 (single-register move) reports 0x03, and class 6 (double-register move) reports 0x04.
- R10: At levels 0 and 1, with hyp_en 1, class 7 (ROM-address access) traps to level 2 with 0x18 when eff_tdra is 1. Class 8 (OS-register access) does the same when eff_tdosa is 1.
- R11: Only bits 50, 43, 41:40, 36, 31:23, 19, 17 and 15:0 hold data (mask 64'h0004_0B10_FF8A_FFFF). All other bits read as zero and ignore writes.
- R12: When hyp_en is 0, every non-configuration access at levels 0 and 1 is allowed. Any non-configuration access at levels 2 and 3, and any access of class 0 or of classes 9 to 15, is allowed. An allowed or undefined response reports target 0 and syndrome 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_enc | input | 16 | Access encoding {op0,op1,CRn,CRm,op2} |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 64 | Write data |
| req_class | input | 4 | Access class code (0 to 8 defined) |
| req_level | input | 2 | Current privilege level |
| hyp_en | input | 1 | Hypervisor level enabled for the current state |
| gen_trap | input | 1 | General-trap flag forcing debug routing |
| nest_virt | input | 1 | Nested virtualisation flag |
| upper_trap | input | 1 | Trap bit owned by level 3 |
| rsp_valid | output | 1 | Response valid |
| rsp_kind | output | 2 | 0 allowed, 1 undefined, 2 trapped |
| rsp_target | output | 2 | Level that takes the trap |
| rsp_syndrome | output | 6 | Syndrome code of the trap |
| rsp_rdata | output | 64 | Direct read data of the register |
| eff_tde | output | 1 | Effective debug routing bit |
| eff_tda | output | 1 | Effective debug-register trap bit |
| eff_tdra | output | 1 | Effective ROM-access trap bit |
| eff_tdosa | output | 1 | Effective OS-register trap bit |
| eff_tpm | output | 1 | Effective counter trap bit |

## Verification
The verdict, target, syndrome and read data all come out of a single register stage, so they are due in the cycle after the strobe. The bench drives each request on a falling edge and samples one falling edge after the capturing rising edge. The effective trap outputs follow the stored register and the side flags combinationally. They are sampled one falling edge after a write has landed, or shortly after a side flag changes. The bench sweeps every combination of the five trap bits, the general-trap flag, the enable flag, all levels and all classes. It compares each result with values worked out from the requirements.

// File: rtl/hdbg_pkg.sv
package hdbg_pkg;

    localparam int unsigned ENC_W = 16;
    localparam int unsigned CLS_W = 4;
    localparam int unsigned LVL_W = 2;
    localparam int unsigned SYN_W = 6;

    // {op0, op1, CRn, CRm, op2} of the configuration register
    localparam logic [ENC_W-1:0] CFG_ENC = 16'hE089;

    // stored positions of the trap controls
    localparam int unsigned POS_TPM   = 6;
    localparam int unsigned POS_TDE   = 8;
    localparam int unsigned POS_TDA   = 9;
    localparam int unsigned POS_TDOSA = 10;
    localparam int unsigned POS_TDRA  = 11;

    localparam logic [SYN_W-1:0] SYN_SYS64    = 6'h18;
    localparam logic [SYN_W-1:0] SYN_DBG_MOV  = 6'h05;
    localparam logic [SYN_W-1:0] SYN_DBG_LDST = 6'h06;
    localparam logic [SYN_W-1:0] SYN_PMU_MOV  = 6'h03;
    localparam logic [SYN_W-1:0] SYN_PMU_MOV2 = 6'h04;

    typedef enum logic [1:0] {
        DEC_ALLOW = 2'd0,
        DEC_UNDEF = 2'd1,
        DEC_TRAP  = 2'd2
    } dec_e;

    typedef enum logic [CLS_W-1:0] {
        CLS_PLAIN    = 4'd0,
        CLS_DBG_A64  = 4'd1,
        CLS_DBG_MOV  = 4'd2,
        CLS_DBG_LDST = 4'd3,
        CLS_PMU_A64  = 4'd4,
        CLS_PMU_MOV  = 4'd5,
        CLS_PMU_MOV2 = 4'd6,
        CLS_ROM      = 4'd7,
        CLS_OSREG    = 4'd8
    } cls_e;

    typedef struct packed {
        logic tde;
        logic tda;
        logic tdra;
        logic tdosa;
        logic tpm;
    } ctl_t;

    typedef struct packed {
        dec_e             kind;
        logic [LVL_W-1:0] target;
        logic [SYN_W-1:0] syn;
    } verdict_t;

endpackage

// File: rtl/hdbg_cfg_reg.sv
module hdbg_cfg_reg #(
    parameter int unsigned      XLEN      = 64,
    parameter logic [XLEN-1:0]  KEEP_MASK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] q
);

    logic [XLEN-1:0] val_d;
    logic [XLEN-1:0] val_q;

    always_comb begin
        val_d = val_q;
        if (we) begin
            val_d = wdata & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign q = val_q;

endmodule

// File: rtl/hdbg_eff.sv
module hdbg_eff
    import hdbg_pkg::*;
(
    input  ctl_t stored,
    input  logic gen_trap,
    output ctl_t eff
);

    always_comb begin
        eff       = stored;
        eff.tde   = stored.tde | gen_trap;
        eff.tda   = stored.tda   | eff.tde;
        eff.tdra  = stored.tdra  | eff.tde;
        eff.tdosa = stored.tdosa | eff.tde;
    end

endmodule

// File: rtl/hdbg_decide.sv
module hdbg_decide
    import hdbg_pkg::*;
(
    input  logic             enc_hit,
    input  logic [LVL_W-1:0] level,
    input  logic [CLS_W-1:0] cls,
    input  logic             hyp_en,
    input  logic             nest_virt,
    input  logic             upper_trap,
    input  logic             tda,
    input  logic             tdra,
    input  logic             tdosa,
    input  logic             tpm,
    output verdict_t         verdict,
    output logic             cfg_ok
);

    localparam logic [LVL_W-1:0] LVL_HYP = 2'd2;
    localparam logic [LVL_W-1:0] LVL_TOP = 2'd3;

    function automatic verdict_t trap_to(input logic [LVL_W-1:0] lvl,
                                         input logic [SYN_W-1:0] syn);
        verdict_t v;
        v.kind   = DEC_TRAP;
        v.target = lvl;
        v.syn    = syn;
        return v;
    endfunction

    function automatic verdict_t gated(input logic on,
                                       input logic [SYN_W-1:0] syn);
        verdict_t v;
        v.kind   = DEC_ALLOW;
        v.target = '0;
        v.syn    = '0;
        if (on) begin
            v = trap_to(LVL_HYP, syn);
        end
        return v;
    endfunction

    always_comb begin
        verdict.kind   = DEC_ALLOW;
        verdict.target = '0;
        verdict.syn    = '0;
        cfg_ok         = 1'b0;
        if (enc_hit) begin
            case (level)
                2'd0: verdict.kind = DEC_UNDEF;
                2'd1: begin
                    if (nest_virt) begin
                        verdict = trap_to(LVL_HYP, SYN_SYS64);
                    end else begin
                        verdict.kind = DEC_UNDEF;
                    end
                end
                2'd2: begin
                    if (upper_trap) begin
                        verdict = trap_to(LVL_TOP, SYN_SYS64);
                    end else begin
                        cfg_ok = 1'b1;
                    end
                end
                default: cfg_ok = 1'b1;
            endcase
        end else if (hyp_en && (level < LVL_HYP)) begin
            case (cls_e'(cls))
                CLS_DBG_A64:  verdict = gated(tda,   SYN_SYS64);
                CLS_DBG_MOV:  verdict = gated(tda,   SYN_DBG_MOV);
                CLS_DBG_LDST: verdict = gated(tda,   SYN_DBG_LDST);
                CLS_PMU_A64:  verdict = gated(tpm,   SYN_SYS64);
                CLS_PMU_MOV:  verdict = gated(tpm,   SYN_PMU_MOV);
                CLS_PMU_MOV2: verdict = gated(tpm,   SYN_PMU_MOV2);
                CLS_ROM:      verdict = gated(tdra,  SYN_SYS64);
                CLS_OSREG:    verdict = gated(tdosa, SYN_SYS64);
                default:      verdict.kind = DEC_ALLOW;
            endcase
        end
    end

endmodule

// File: rtl/hdbg_trap_unit.sv
module hdbg_trap_unit
    import hdbg_pkg::*;
#(
    parameter int unsigned     XLEN      = 64,
    parameter logic [XLEN-1:0] KEEP_MASK = 64'h0004_0B10_FF8A_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [ENC_W-1:0] req_enc,
    input  logic             req_write,
    input  logic [XLEN-1:0]  req_wdata,
    input  logic [CLS_W-1:0] req_class,
    input  logic [LVL_W-1:0] req_level,
    input  logic             hyp_en,
    input  logic             gen_trap,
    input  logic             nest_virt,
    input  logic             upper_trap,
    output logic             rsp_valid,
    output logic [1:0]       rsp_kind,
    output logic [LVL_W-1:0] rsp_target,
    output logic [SYN_W-1:0] rsp_syndrome,
    output logic [XLEN-1:0]  rsp_rdata,
    output logic             eff_tde,
    output logic             eff_tda,
    output logic             eff_tdra,
    output logic             eff_tdosa,
    output logic             eff_tpm
);

    typedef struct packed {
        logic            valid;
        verdict_t        verdict;
        logic [XLEN-1:0] rdata;
    } rsp_t;

    logic [XLEN-1:0] stored;
    ctl_t            stored_ctl;
    ctl_t            eff;
    verdict_t        verdict;
    logic            cfg_ok;
    logic            cfg_we;
    rsp_t            rsp_d;
    rsp_t            rsp_q;

    assign stored_ctl.tde   = stored[POS_TDE];
    assign stored_ctl.tda   = stored[POS_TDA];
    assign stored_ctl.tdra  = stored[POS_TDRA];
    assign stored_ctl.tdosa = stored[POS_TDOSA];
    assign stored_ctl.tpm   = stored[POS_TPM];

    hdbg_eff u_eff (
        .stored   (stored_ctl),
        .gen_trap (gen_trap),
        .eff      (eff)
    );

    hdbg_decide u_decide (
        .enc_hit    (req_enc == CFG_ENC),
        .level      (req_level),
        .cls        (req_class),
        .hyp_en     (hyp_en),
        .nest_virt  (nest_virt),
        .upper_trap (upper_trap),
        .tda        (eff.tda),
        .tdra       (eff.tdra),
        .tdosa      (eff.tdosa),
        .tpm        (eff.tpm),
        .verdict    (verdict),
        .cfg_ok     (cfg_ok)
    );

    assign cfg_we = req_valid & cfg_ok & req_write;

    hdbg_cfg_reg #(
        .XLEN      (XLEN),
        .KEEP_MASK (KEEP_MASK)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (req_wdata),
        .q     (stored)
    );

    always_comb begin
        rsp_d.valid          = req_valid;
        rsp_d.verdict.kind   = DEC_ALLOW;
        rsp_d.verdict.target = '0;
        rsp_d.verdict.syn    = '0;
        rsp_d.rdata          = '0;
        if (req_valid) begin
            rsp_d.verdict = verdict;
            if (cfg_ok && !req_write) begin
                rsp_d.rdata = stored;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q.valid          <= 1'b0;
            rsp_q.verdict.kind   <= DEC_ALLOW;
            rsp_q.verdict.target <= '0;
            rsp_q.verdict.syn    <= '0;
            rsp_q.rdata          <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_kind     = rsp_q.verdict.kind;
    assign rsp_target   = rsp_q.verdict.target;
    assign rsp_syndrome = rsp_q.verdict.syn;
    assign rsp_rdata    = rsp_q.rdata;

    assign eff_tde   = eff.tde;
    assign eff_tda   = eff.tda;
    assign eff_tdra  = eff.tdra;
    assign eff_tdosa = eff.tdosa;
    assign eff_tpm   = eff.tpm;

endmodule

// File: rtl/hdbg_trap_chk.sv
module hdbg_trap_chk
    import hdbg_pkg::*;
#(
    parameter int unsigned     XLEN      = 64,
    parameter logic [XLEN-1:0] KEEP_MASK = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [ENC_W-1:0] req_enc,
    input logic [LVL_W-1:0] req_level,
    input logic             hyp_en,
    input logic             nest_virt,
    input logic             gen_trap,
    input logic             rsp_valid,
    input logic [1:0]       rsp_kind,
    input logic [LVL_W-1:0] rsp_target,
    input logic [XLEN-1:0]  rsp_rdata,
    input logic             eff_tde,
    input logic             eff_tda,
    input logic             eff_tdra,
    input logic             eff_tdosa
);

    a_r2_lvl0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_enc == CFG_ENC && req_level == 2'd0) |=> (rsp_kind == DEC_UNDEF));

    a_r3_no_nest_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_enc == CFG_ENC && req_level == 2'd1 && !nest_virt) |=> (rsp_kind == DEC_UNDEF));

    a_r4_top_allows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_enc == CFG_ENC && req_level == 2'd3) |=> (rsp_kind == DEC_ALLOW));

    a_r5_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r5_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r6_gen_forces: assert property (@(posedge clk) disable iff (!rst_n)
        gen_trap |-> eff_tde);

    a_r7_route_forces: assert property (@(posedge clk) disable iff (!rst_n)
        eff_tde |-> (eff_tda && eff_tdra && eff_tdosa));

    a_r8_trap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_kind == DEC_TRAP) |-> (rsp_target >= 2'd2));

    a_r11_res0: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsp_rdata & ~KEEP_MASK) == '0));

    a_r12_hyp_off: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hyp_en && req_enc != CFG_ENC) |=> (rsp_kind == DEC_ALLOW));

endmodule

bind hdbg_trap_unit hdbg_trap_chk #(
    .XLEN      (XLEN),
    .KEEP_MASK (KEEP_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_enc    (req_enc),
    .req_level  (req_level),
    .hyp_en     (hyp_en),
    .nest_virt  (nest_virt),
    .gen_trap   (gen_trap),
    .rsp_valid  (rsp_valid),
    .rsp_kind   (rsp_kind),
    .rsp_target (rsp_target),
    .rsp_rdata  (rsp_rdata),
    .eff_tde    (eff_tde),
    .eff_tda    (eff_tda),
    .eff_tdra   (eff_tdra),
    .eff_tdosa  (eff_tdosa)
);

// File: tb/sim_hdbg_trap_unit.sv
module sim_hdbg_trap_unit;

    localparam logic [15:0] ENC_CFG = 16'hE089;
    localparam logic [63:0] MASK    = 64'h0004_0B10_FF8A_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_enc = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [3:0]  req_class = '0;
    logic [1:0]  req_level = '0;
    logic        hyp_en = 1'b0;
    logic        gen_trap = 1'b0;
    logic        nest_virt = 1'b0;
    logic        upper_trap = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [1:0]  rsp_target;
    logic [5:0]  rsp_syndrome;
    logic [63:0] rsp_rdata;
    logic        eff_tde, eff_tda, eff_tdra, eff_tdosa, eff_tpm;

    int checks = 0;
    int errors = 0;
    logic [63:0] shadow = '0;

    always #4 clk = ~clk;

    hdbg_trap_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_enc(req_enc),
        .req_write(req_write), .req_wdata(req_wdata), .req_class(req_class),
        .req_level(req_level), .hyp_en(hyp_en), .gen_trap(gen_trap),
        .nest_virt(nest_virt), .upper_trap(upper_trap), .rsp_valid(rsp_valid),
        .rsp_kind(rsp_kind), .rsp_target(rsp_target), .rsp_syndrome(rsp_syndrome),
        .rsp_rdata(rsp_rdata), .eff_tde(eff_tde), .eff_tda(eff_tda),
        .eff_tdra(eff_tdra), .eff_tdosa(eff_tdosa), .eff_tpm(eff_tpm)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] enc, input logic wr, input logic [63:0] wd,
                          input logic [3:0] cls, input logic [1:0] lvl);
        @(negedge clk);
        req_enc   = enc;
        req_write = wr;
        req_wdata = wd;
        req_class = cls;
        req_level = lvl;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    // {kind, target, syndrome} expected for a non-configuration access
    function automatic logic [9:0] exp_plain(input logic [3:0] cls, input logic [1:0] lvl,
                                             input logic hyp, input logic [4:0] e);
        // e = {tde, tda, tdra, tdosa, tpm} effective
        logic on;
        logic [5:0] syn;
        on = 1'b0;
        syn = 6'h00;
        case (cls)
            4'd1: begin on = e[3]; syn = 6'h18; end
            4'd2: begin on = e[3]; syn = 6'h05; end
            4'd3: begin on = e[3]; syn = 6'h06; end
            4'd4: begin on = e[0]; syn = 6'h18; end
            4'd5: begin on = e[0]; syn = 6'h03; end
            4'd6: begin on = e[0]; syn = 6'h04; end
            4'd7: begin on = e[2]; syn = 6'h18; end
            4'd8: begin on = e[1]; syn = 6'h18; end
            default: on = 1'b0;
        endcase
        if (hyp && lvl <= 2'd1 && on) return {2'd2, 2'd2, syn};
        return 10'd0;
    endfunction

    function automatic string tag_of(input logic [3:0] cls, input logic hyp, input logic [1:0] lvl);
        if (!hyp || lvl > 2'd1) return "R12";
        if (cls >= 4'd1 && cls <= 4'd3) return "R8";
        if (cls >= 4'd4 && cls <= 4'd6) return "R9";
        if (cls >= 4'd7 && cls <= 4'd8) return "R10";
        return "R12";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R1 eff", {59'd0, eff_tde, eff_tda, eff_tdra, eff_tdosa, eff_tpm}, 64'd0);
        access(ENC_CFG, 1'b0, '0, 4'd0, 2'd3);
        chk("R1 read zero", rsp_rdata, 64'd0);
        chk("R5 valid after strobe", {63'd0, rsp_valid}, 64'd1);
        @(negedge clk);
        chk("R5 valid drops", {63'd0, rsp_valid}, 64'd0);

        // R2 R3 R4: configuration-register access sweep (reads)
        for (int l = 0; l < 4; l++) begin
            for (int n = 0; n < 2; n++) begin
                for (int u = 0; u < 2; u++) begin
                    logic [9:0] e;
                    nest_virt  = n[0];
                    upper_trap = u[0];
                    access(ENC_CFG, 1'b0, '0, 4'd1, 2'(l));
                    if (l == 0) e = {2'd1, 2'd0, 6'h00};
                    else if (l == 1) e = n[0] ? {2'd2, 2'd2, 6'h18} : {2'd1, 2'd0, 6'h00};
                    else if (l == 2) e = u[0] ? {2'd2, 2'd3, 6'h18} : 10'd0;
                    else e = 10'd0;
                    chk(l == 0 ? "R2 verdict" : (l == 1 ? "R3 verdict" : "R4 verdict"),
                        {54'd0, rsp_kind, rsp_target, rsp_syndrome}, {54'd0, e});
                end
            end
        end

        // R3/R4: trapped or undefined writes leave the register unchanged
        nest_virt = 1'b1; upper_trap = 1'b1;
        access(ENC_CFG, 1'b1, 64'h0000_0000_0000_0F40, 4'd0, 2'd1);
        access(ENC_CFG, 1'b1, 64'h0000_0000_0000_0F40, 4'd0, 2'd2);
        access(ENC_CFG, 1'b1, 64'h0000_0000_0000_0F40, 4'd0, 2'd0);
        access(ENC_CFG, 1'b0, '0, 4'd0, 2'd3);
        chk("R3 R4 blocked write", rsp_rdata, 64'd0);
        upper_trap = 1'b0; nest_virt = 1'b0;
        access(ENC_CFG, 1'b1, 64'h0000_0000_1234_5678, 4'd0, 2'd2);
        chk("R5 write response", {62'd0, rsp_kind}, 64'd0);
        access(ENC_CFG, 1'b0, '0, 4'd0, 2'd3);
        chk("R4 level2 write", rsp_rdata, 64'h0000_0000_1234_5678 & MASK);

        // R11: reserved bits
        access(ENC_CFG, 1'b1, '1, 4'd0, 2'd3);
        access(ENC_CFG, 1'b0, '0, 4'd0, 2'd2);
        chk("R11 ones", rsp_rdata, MASK);
        access(ENC_CFG, 1'b1, ~MASK, 4'd0, 2'd3);
        access(ENC_CFG, 1'b0, '0, 4'd0, 2'd3);
        chk("R11 reserved only", rsp_rdata, 64'd0);

        // Sweep of trap bits, general trap, enable, level and class
        for (int p = 0; p < 32; p++) begin
            logic [63:0] wd;
            wd = 64'h0004_0000_0000_0001;
            wd[6]  = p[0];
            wd[8]  = p[1];
            wd[9]  = p[2];
            wd[11] = p[3];
            wd[10] = p[4];
            gen_trap = 1'b0;
            access(ENC_CFG, 1'b1, wd, 4'd0, 2'd3);
            shadow = wd & MASK;
            for (int g = 0; g < 2; g++) begin
                logic [4:0] e;
                logic t;
                gen_trap = g[0];
                #1;
                t = shadow[8] | g[0];
                e = {t, shadow[9] | t, shadow[11] | t, shadow[10] | t, shadow[6]};
                chk(g[0] ? "R6 R7 eff" : "R7 eff",
                    {59'd0, eff_tde, eff_tda, eff_tdra, eff_tdosa, eff_tpm}, {59'd0, e});
                access(ENC_CFG, 1'b0, '0, 4'd0, 2'd3);
                chk("R7 direct read", rsp_rdata, shadow);
                for (int h = 0; h < 2; h++) begin
                    hyp_en = h[0];
                    for (int l = 0; l < 4; l++) begin
                        for (int c = 0; c < 10; c++) begin
                            access(16'h0000, 1'b0, '0, 4'(c), 2'(l));
                            chk(tag_of(4'(c), h[0], 2'(l)),
                                {54'd0, rsp_kind, rsp_target, rsp_syndrome},
                                {54'd0, exp_plain(4'(c), 2'(l), h[0], e)});
                        end
                    end
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule